// File: doc/BRIEF.md
# Three-Bank Level Interrupt Aggregator with Shortcut Folding

This block gathers 72 level-sensitive interrupt lines into three groups: a small primary group of 8 lines and two wide secondary groups of 32 lines each. Every line has an enable bit. Software turns enable bits on through a set register and off through a clear register for each group, and it reads masked status through a per-group pending register. A pending bit is high while its source is high and enabled. It goes low only when the peripheral drops the line.

The primary group's status word is the first register a handler reads. Besides the 8 primary lines, it has one summary bit for each secondary group. It also folds eleven chosen secondary lines directly into their own bit positions, so a handler can identify those lines from a single read. A folded line never raises its group's summary bit, and neither the summary bits nor the folded bits can be masked from the primary group. One combined interrupt output is high whenever any meaningful bit of the primary status word is set.

The register port is a single-cycle interface. A write takes effect on the clock edge where `bus_wr` is high. Read data is a combinational function of `bus_addr` and is valid in the same cycle.

Top module: `banked_irq_ctrl`

## Requirements
- R1: After reset every enable bit is 0, every register reads 0 and `irq_out` is low.
- R2: A write to offset 0x10, 0x14 or 0x18 (groups 1, 2, 0) sets each enable bit whose data bit is 1 and leaves bits written with 0 unchanged. Reading the same offset returns that group's enable mask, zero-extended.
- R3: A write to offset 0x1C, 0x20 or 0x24 (groups 1, 2, 0) clears each enable bit whose data bit is 1 and leaves the others unchanged.
- R4: Offsets 0x04 and 0x08 read group 1 and group 2 source lines ANDed with their enables. The value follows the live inputs in the same cycle.
- R5: Bits 7:0 at offset 0x00 are the group 0 source lines ANDed with the group 0 enables.
- R6: Bit 8 at offset 0x00 is high exactly when group 1 has an enabled, high line that is not folded. Bit 9 does the same for group 2.
- R7: Group 1 lines 7, 9, 10, 18 and 19 appear, enabled, at offset 0x00 bits 10, 11, 12, 13 and 14. Group 2 lines 21, 22, 23, 24, 25 and 30 appear at bits 15 to 20. A folded line still shows in its own group's register and does not raise bit 8 or bit 9.
- R8: Data bits 31:8 of writes to offsets 0x18 and 0x24 have no effect. In particular they cannot mask or unmask folded bits or summary bits.
- R9: `irq_out` is the OR of bits 20:0 at offset 0x00.
- R10: Bits 31:21 at offset 0x00, the clear offsets, and every other offset (including unaligned byte addresses) read 0. Writes to offsets other than the six enable and clear offsets change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_b0 | input | 8 | Group 0 level sources |
| src_b1 | input | 32 | Group 1 level sources |
| src_b2 | input | 32 | Group 2 level sources |
| bus_wr | input | 1 | Write strobe for the current cycle |
| bus_addr | input | 6 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq_out | output | 1 | Combined interrupt request |

## Verification
The bench builds the block with its default parameters: 8 primary lines, 32 lines per secondary group, a 32-bit data path and a 6-bit address. At this size the full byte-address space of 64 locations can be read after every step. The bench sweeps each of the 72 lines one at a time through enable, pending and clear, so every folded line and every summary path is visited. Random source levels and random writes to random addresses, checked against an arithmetic model, then cover mixed folded and unfolded lines and writes to undefined offsets.

// File: rtl/bic_pkg.sv
package bic_pkg;

   // Register byte offsets.
   localparam logic [5:0] OFS_PEND0 = 6'h00;
   localparam logic [5:0] OFS_PEND1 = 6'h04;
   localparam logic [5:0] OFS_PEND2 = 6'h08;
   localparam logic [5:0] OFS_SET1  = 6'h10;
   localparam logic [5:0] OFS_SET2  = 6'h14;
   localparam logic [5:0] OFS_SET0  = 6'h18;
   localparam logic [5:0] OFS_CLR1  = 6'h1C;
   localparam logic [5:0] OFS_CLR2  = 6'h20;
   localparam logic [5:0] OFS_CLR0  = 6'h24;

   // Number of folded lines per secondary group.
   localparam int unsigned N_FOLD1 = 5;
   localparam int unsigned N_FOLD2 = 6;

   // Source index of the k-th folded line in a secondary group.
   function automatic int unsigned fold_src(int unsigned grp, int unsigned k);
      int unsigned r;
      r = 0;
      if (grp == 1) begin
         case (k)
            0: r = 7;
            1: r = 9;
            2: r = 10;
            3: r = 18;
            default: r = 19;
         endcase
      end else begin
         case (k)
            0: r = 21;
            1: r = 22;
            2: r = 23;
            3: r = 24;
            4: r = 25;
            default: r = 30;
         endcase
      end
      return r;
   endfunction

   function automatic int unsigned fold_count(int unsigned grp);
      return (grp == 1) ? N_FOLD1 : N_FOLD2;
   endfunction

   // Bit mask of the folded lines in a secondary group.
   function automatic logic [31:0] fold_mask(int unsigned grp);
      logic [31:0] m;
      m = '0;
      for (int unsigned k = 0; k < fold_count(grp); k++)
         m[fold_src(grp, k)] = 1'b1;
      return m;
   endfunction

endpackage

// File: rtl/bic_en_reg.sv
module bic_en_reg #(
   parameter int unsigned N = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         set_we,
   input  logic         clr_we,
   input  logic [N-1:0] bits,
   output logic [N-1:0] en
);

   if (N < 1 || N > 32) begin : g_bad_n
      $error("bic_en_reg: N must lie in 1..32");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      en <= '0;
      else if (set_we) en <= en | bits;
      else if (clr_we) en <= en & ~bits;
   end

   // R2: bits written with 1 are set afterwards
   a_r2_set_takes: assert property (@(posedge clk) disable iff (!rst_n)
      set_we |=> ((en & $past(bits)) == $past(bits)));
   // R2: bits written with 0 keep their value
   a_r2_zero_keeps: assert property (@(posedge clk) disable iff (!rst_n)
      (set_we || clr_we) |=> ((en & ~$past(bits)) == ($past(en) & ~$past(bits))));
   // R3: bits written with 1 are cleared afterwards
   a_r3_clr_takes: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_we && !set_we) |=> ((en & $past(bits)) == '0));
   // R10: no strobe, no change
   a_r10_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!set_we && !clr_we) |=> $stable(en));

endmodule

// File: rtl/bic_shortcut_fold.sv
module bic_shortcut_fold #(
   parameter int unsigned BK_N = 32,
   parameter int unsigned GRP  = 1,
   localparam int unsigned NF  = bic_pkg::fold_count(GRP)
) (
   input  logic [BK_N-1:0] pend,
   output logic [NF-1:0]   fold,
   output logic            summary
);

   localparam logic [31:0] FMASK = bic_pkg::fold_mask(GRP);

   if (GRP != 1 && GRP != 2) begin : g_bad_grp
      $error("bic_shortcut_fold: GRP must be 1 or 2");
   end
   if (BK_N != 32) begin : g_bad_w
      $error("bic_shortcut_fold: folded lines need a 32-line group");
   end

   for (genvar k = 0; k < NF; k++) begin : g_fold
      localparam int unsigned IDX = bic_pkg::fold_src(GRP, k);
      assign fold[k] = pend[IDX];
   end

   assign summary = |(pend & ~FMASK[BK_N-1:0]);

endmodule

// File: rtl/banked_irq_ctrl.sv
module banked_irq_ctrl #(
   parameter int unsigned B0_N = 8,
   parameter int unsigned BK_N = 32,
   parameter int unsigned DW   = 32,
   parameter int unsigned AW   = 6
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [B0_N-1:0] src_b0,
   input  logic [BK_N-1:0] src_b1,
   input  logic [BK_N-1:0] src_b2,
   input  logic          bus_wr,
   input  logic [AW-1:0] bus_addr,
   input  logic [DW-1:0] bus_wdata,
   output logic [DW-1:0] bus_rdata,
   output logic          irq_out
);
   import bic_pkg::*;

   localparam int unsigned SUM1_POS  = B0_N;
   localparam int unsigned SUM2_POS  = B0_N + 1;
   localparam int unsigned FOLD1_POS = B0_N + 2;
   localparam int unsigned FOLD2_POS = FOLD1_POS + N_FOLD1;
   localparam int unsigned USED      = FOLD2_POS + N_FOLD2;

   if (USED > DW) begin : g_bad_dw
      $error("banked_irq_ctrl: status word does not fit DW");
   end
   if (BK_N > DW) begin : g_bad_bk
      $error("banked_irq_ctrl: group wider than DW");
   end
   if (AW != 6) begin : g_bad_aw
      $error("banked_irq_ctrl: AW must be 6");
   end

   logic [B0_N-1:0] en0;
   logic [BK_N-1:0] en1, en2;
   logic [B0_N-1:0] pend0;
   logic [BK_N-1:0] pend1, pend2;
   logic [N_FOLD1-1:0] fold1;
   logic [N_FOLD2-1:0] fold2;
   logic sum1, sum2;
   logic [DW-1:0] stat0;

   bic_en_reg #(.N(B0_N)) u_en0 (
      .clk(clk), .rst_n(rst_n),
      .set_we(bus_wr && bus_addr == OFS_SET0),
      .clr_we(bus_wr && bus_addr == OFS_CLR0),
      .bits(bus_wdata[B0_N-1:0]), .en(en0));

   bic_en_reg #(.N(BK_N)) u_en1 (
      .clk(clk), .rst_n(rst_n),
      .set_we(bus_wr && bus_addr == OFS_SET1),
      .clr_we(bus_wr && bus_addr == OFS_CLR1),
      .bits(bus_wdata[BK_N-1:0]), .en(en1));

   bic_en_reg #(.N(BK_N)) u_en2 (
      .clk(clk), .rst_n(rst_n),
      .set_we(bus_wr && bus_addr == OFS_SET2),
      .clr_we(bus_wr && bus_addr == OFS_CLR2),
      .bits(bus_wdata[BK_N-1:0]), .en(en2));

   assign pend0 = src_b0 & en0;
   assign pend1 = src_b1 & en1;
   assign pend2 = src_b2 & en2;

   bic_shortcut_fold #(.BK_N(BK_N), .GRP(1)) u_fold1 (
      .pend(pend1), .fold(fold1), .summary(sum1));
   bic_shortcut_fold #(.BK_N(BK_N), .GRP(2)) u_fold2 (
      .pend(pend2), .fold(fold2), .summary(sum2));

   always_comb begin
      stat0 = '0;
      stat0[B0_N-1:0] = pend0;
      stat0[SUM1_POS] = sum1;
      stat0[SUM2_POS] = sum2;
      stat0[FOLD1_POS +: N_FOLD1] = fold1;
      stat0[FOLD2_POS +: N_FOLD2] = fold2;
   end

   always_comb begin
      bus_rdata = '0;
      case (bus_addr)
         OFS_PEND0: bus_rdata = stat0;
         OFS_PEND1: bus_rdata[BK_N-1:0] = pend1;
         OFS_PEND2: bus_rdata[BK_N-1:0] = pend2;
         OFS_SET0:  bus_rdata[B0_N-1:0] = en0;
         OFS_SET1:  bus_rdata[BK_N-1:0] = en1;
         OFS_SET2:  bus_rdata[BK_N-1:0] = en2;
         default:   bus_rdata = '0;
      endcase
   end

   assign irq_out = |stat0[USED-1:0];

   // R9: any enabled high line in any group reaches the output
   a_r9_grp1_reaches: assert property (@(posedge clk) disable iff (!rst_n)
      (pend1 != '0) |-> irq_out);
   a_r9_grp2_reaches: assert property (@(posedge clk) disable iff (!rst_n)
      (pend2 != '0) |-> irq_out);
   // R5: primary lines reach the output
   a_r5_grp0_reaches: assert property (@(posedge clk) disable iff (!rst_n)
      (pend0 != '0) |-> irq_out);
   // R10: unused status bits read zero
   a_r10_hi_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_addr == OFS_PEND0) |-> (bus_rdata[DW-1:USED] == '0));
   // R7: a folded line never shows without its group pending
   a_r7_fold_backed: assert property (@(posedge clk) disable iff (!rst_n)
      (fold1 != '0) |-> (pend1 != '0));

endmodule

// File: tb/test_banked_irq_ctrl.sv
module test_banked_irq_ctrl;

   logic clk = 1'b0;
   always #10 clk = ~clk;

   logic        rst_n;
   logic [7:0]  src_b0;
   logic [31:0] src_b1, src_b2;
   logic        bus_wr;
   logic [5:0]  bus_addr;
   logic [31:0] bus_wdata;
   logic [31:0] bus_rdata;
   logic        irq_out;

   banked_irq_ctrl i_banked_irq_ctrl (
      .clk(clk), .rst_n(rst_n), .src_b0(src_b0), .src_b1(src_b1),
      .src_b2(src_b2), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_out(irq_out));

   int total = 0;
   int bad = 0;
   bit done = 0;
   logic [7:0]  m0;
   logic [31:0] m1, m2;
   logic [31:0] rs = 32'h1234_5678;

   function automatic logic [31:0] nxt(logic [31:0] x);
      logic [31:0] y;
      y = x ^ (x << 13);
      y = y ^ (y >> 17);
      y = y ^ (y << 5);
      return y;
   endfunction

   function automatic logic [31:0] exp_stat0();
      int l1[5] = '{7, 9, 10, 18, 19};
      int l2[6] = '{21, 22, 23, 24, 25, 30};
      logic [31:0] p1, p2, r;
      p1 = src_b1 & m1;
      p2 = src_b2 & m2;
      r = {24'h0, src_b0 & m0};
      for (int k = 0; k < 5; k++) begin
         r[10+k] = p1[l1[k]];
         p1[l1[k]] = 1'b0;
      end
      for (int k = 0; k < 6; k++) begin
         r[15+k] = p2[l2[k]];
         p2[l2[k]] = 1'b0;
      end
      r[8] = |p1;
      r[9] = |p2;
      return r;
   endfunction

   function automatic logic [31:0] exp_reg(logic [5:0] a);
      case (a)
         6'h00: return exp_stat0();
         6'h04: return src_b1 & m1;
         6'h08: return src_b2 & m2;
         6'h10: return m1;
         6'h14: return m2;
         6'h18: return {24'h0, m0};
         default: return 32'h0;
      endcase
   endfunction

   function automatic string tag_of(logic [5:0] a);
      case (a)
         6'h00: return "R5/R6/R7";
         6'h04, 6'h08: return "R4";
         6'h10, 6'h14, 6'h18: return "R2";
         default: return "R10";
      endcase
   endfunction

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wr(logic [5:0] a, logic [31:0] d);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0; bus_wdata = '0;
      case (a)
         6'h10: m1 = m1 | d;
         6'h14: m2 = m2 | d;
         6'h18: m0 = m0 | d[7:0];
         6'h1C: m1 = m1 & ~d;
         6'h20: m2 = m2 & ~d;
         6'h24: m0 = m0 & ~d[7:0];
         default: ;
      endcase
   endtask

   task automatic rd(logic [5:0] a, string tag, logic [31:0] exp);
      @(negedge clk);
      bus_addr = a;
      #1;
      chk(tag, bus_rdata, exp);
   endtask

   task automatic irq_chk(string tag, logic exp);
      #1;
      chk(tag, {31'h0, irq_out}, {31'h0, exp});
   endtask

   task automatic check_all(string why);
      for (int a = 0; a < 64; a++)
         rd(a[5:0], (why != "") ? why : tag_of(a[5:0]), exp_reg(a[5:0]));
      irq_chk((why != "") ? why : "R9", |exp_stat0()[20:0]);
   endtask

   task automatic clear_all();
      wr(6'h1C, 32'hFFFF_FFFF);
      wr(6'h20, 32'hFFFF_FFFF);
      wr(6'h24, 32'hFFFF_FFFF);
   endtask

   initial begin
      #(20 * 150000);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      rst_n = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
      src_b0 = 8'hFF; src_b1 = '1; src_b2 = '1;
      m0 = '0; m1 = '0; m2 = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1: reset state with all sources high
      check_all("R1");

      // Group 1 sweep: R4, R6/R7, R9, R3
      src_b0 = '0; src_b2 = '0;
      for (int i = 0; i < 32; i++) begin
         clear_all();
         src_b1 = 32'h1 << i;
         rd(6'h00, "R4", 32'h0);
         wr(6'h10, 32'h1 << i);
         rd(6'h04, "R4", 32'h1 << i);
         rd(6'h00, "R6/R7", exp_stat0());
         irq_chk("R9", 1'b1);
         wr(6'h1C, 32'h1 << i);
         rd(6'h04, "R3", 32'h0);
         irq_chk("R3", 1'b0);
      end
      // Group 2 sweep
      src_b1 = '0;
      for (int i = 0; i < 32; i++) begin
         clear_all();
         src_b2 = 32'h1 << i;
         wr(6'h14, 32'h1 << i);
         rd(6'h08, "R4", 32'h1 << i);
         rd(6'h00, "R6/R7", exp_stat0());
         irq_chk("R9", 1'b1);
         wr(6'h20, 32'h1 << i);
         rd(6'h08, "R3", 32'h0);
      end
      // Group 0 sweep
      src_b2 = '0;
      for (int i = 0; i < 8; i++) begin
         clear_all();
         src_b0 = 8'h1 << i;
         wr(6'h18, 32'h1 << i);
         rd(6'h00, "R5", 32'h1 << i);
         irq_chk("R9", 1'b1);
         wr(6'h24, 32'h1 << i);
         rd(6'h00, "R3", 32'h0);
      end

      // Fixed positions
      clear_all();
      src_b0 = '0; src_b1 = 32'h0000_0081; src_b2 = 32'h4000_0000;
      wr(6'h10, 32'hFFFF_FFFF);
      rd(6'h00, "R6", 32'h0000_0500);
      wr(6'h14, 32'hFFFF_FFFF);
      rd(6'h00, "R7", 32'h0010_0500);
      src_b1 = 32'h0000_0080;
      rd(6'h00, "R7", 32'h0010_0400);
      rd(6'h04, "R7", 32'h0000_0080);

      // R8: upper bits of group 0 writes are inert
      clear_all();
      src_b1 = 32'h0000_0080; src_b2 = '0;
      wr(6'h18, 32'hFFFF_FF00);
      rd(6'h18, "R8", 32'h0);
      rd(6'h00, "R8", 32'h0);
      wr(6'h10, 32'h0000_0080);
      wr(6'h24, 32'hFFFF_FF00);
      rd(6'h00, "R8", 32'h0000_0400);
      src_b1 = 32'h0000_0001;
      wr(6'h10, 32'h0000_0001);
      wr(6'h24, 32'hFFFF_FF00);
      rd(6'h00, "R8", 32'h0000_0100);
      irq_chk("R8", 1'b1);

      // Random sources and writes to every address
      for (int n = 0; n < 150; n++) begin
         rs = nxt(rs); src_b0 = rs[7:0];
         rs = nxt(rs); src_b1 = rs & nxt(rs);
         rs = nxt(rs); src_b2 = rs | nxt(rs);
         rs = nxt(rs);
         wr(rs[5:0], nxt(rs));
         rs = nxt(nxt(rs));
         check_all("");
      end

      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule